// File: doc/BRIEF.md
# Keyed Watchdog Timer with Posted Slow-Domain Writes

This block is a watchdog timer. Its counter runs in a slow clock domain, typically around 32 kHz, and software controls it from a faster bus clock through a small register window. The counter counts upward. When it wraps past all-ones while the timer is running, the block drives a reset request for a fixed number of slow cycles. Software keeps the system alive by writing a new trigger value, which reloads the counter from the load register. The usual practice is to alternate between a value and its complement.

Software can only start or stop the timer with a two-word key sequence. A single stray write therefore cannot change the run state. A register write does not act at once. It is posted across to the slow domain through a two-flop synchronizer. A separate pending bit stays set until the slow domain acknowledges that write. While a register's pending bit is set, further writes to that register are dropped. Reads of the live counter return a snapshot that the slow domain publishes on each of its cycles.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the timer is stopped. The load register and the counter both hold 0xFFFF_FFF0, the prescaler is off, every pending bit is 0 and the reset request is low.
- R2: The register window is read combinationally from `bus_addr`. The addresses are: 0 revision (bits 7:0 = REV_CODE, other bits 0), 1 control (bit 5 prescale enable, bits 4:2 exponent, other bits 0), 2 counter snapshot, 3 load, 4 trigger, 5 key, 6 pending. Address 7 reads 0. Control, load, trigger and key read back the last write that was accepted.
- R3: An accepted write sets its pending bit: control bit 0, load bit 2, trigger bit 3, key bit 4. The write takes effect on the third slow edge after the bus edge that accepted it. The pending bit clears after the second bus edge that follows that slow edge.
- R4: A write to a register whose pending bit is set is ignored and leaves the read-back value unchanged.
- R5: Key word 0x0000_BBBB followed by key word 0x0000_4444 starts the timer.
- R6: Key word 0x0000_AAAA followed by key word 0x0000_5555 stops the timer.
- R7: If the word after an arming word is not the matching second word, the sequence is abandoned and the run state stays as it was. A first word that is neither arming word is ignored.
- R8: While the timer runs, the counter advances by one on every tick. While it is stopped, the counter holds its value.
- R9: With the prescale enable at 0, a tick occurs on every slow cycle. With it at 1, a tick occurs once every 2^exponent slow cycles. Landing a control write restarts the prescale count.
- R10: A trigger write that lands reloads the counter from the load register only when its value differs from the last trigger value that caused a reload (initially 0). A reload takes priority over a tick.
- R11: When a tick wraps a running counter from all-ones to zero, `wdt_rst_req` goes high for exactly RST_CYCLES slow cycles, starting at that edge. Counting continues from zero.
- R12: A counter read returns the value the counter held before a slow edge. That value becomes visible from the third bus edge after the slow edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Bus-domain synchronous reset, active low |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | Write qualifier for a bus access |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the register at bus_addr |
| sclk | input | 1 | Slow counting clock |
| srst_n | input | 1 | Slow-domain synchronous reset, active low |
| wdt_rst_req | output | 1 | Reset request pulse, slow domain |

## Verification
The embedded assertions check these properties on every cycle:
- A pending bit rises only after a write strobe.
- Posted data stays frozen while its write is in flight.
- The run state changes only on a key landing.
- A stopped counter, or a repeated trigger value, leaves the counter unchanged.
- A reset request begins only from a running timer.

The exact cycle on which each write lands and acknowledges, the prescale cadence, the reset pulse length and the snapshot lag can only be shown by the bench's scenarios. In those scenarios a timed reference model is compared against every read and every slow cycle of the reset output.

// File: rtl/kwd_pkg.sv
// Shared constants and types for the keyed watchdog.
// Assumes a 3-bit word address and four posted-write channels.
package kwd_pkg;

    localparam int NUM_CH  = 4;
    localparam int CH_CTRL = 0;
    localparam int CH_LOAD = 1;
    localparam int CH_TRIG = 2;
    localparam int CH_KEY  = 3;

    typedef enum logic [2:0] {
        A_REV  = 3'd0,
        A_CTRL = 3'd1,
        A_CNT  = 3'd2,
        A_LOAD = 3'd3,
        A_TRIG = 3'd4,
        A_KEY  = 3'd5,
        A_PEND = 3'd6,
        A_NONE = 3'd7
    } kwd_addr_e;

    localparam logic [31:0] KEY_ON_1  = 32'h0000_BBBB;
    localparam logic [31:0] KEY_ON_2  = 32'h0000_4444;
    localparam logic [31:0] KEY_OFF_1 = 32'h0000_AAAA;
    localparam logic [31:0] KEY_OFF_2 = 32'h0000_5555;

    typedef enum logic [1:0] {
        KS_IDLE = 2'd0,
        KS_ON   = 2'd1,
        KS_OFF  = 2'd2
    } kwd_key_e;

    // Bus address of each posted channel.
    function automatic logic [2:0] ch_addr(int ch);
        case (ch)
            CH_CTRL: return A_CTRL;
            CH_LOAD: return A_LOAD;
            CH_TRIG: return A_TRIG;
            default: return A_KEY;
        endcase
    endfunction

    // Bit of the pending register owned by each channel.
    function automatic int ch_pend_bit(int ch);
        case (ch)
            CH_CTRL: return 0;
            CH_LOAD: return 2;
            CH_TRIG: return 3;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/kwd_post_chan.sv
// One posted-write channel from the bus clock into the slow clock.
// The bus side holds the data and flips a request toggle. The slow side
// synchronizes the toggle through two flops and pulses `land` for one slow
// cycle, then returns an acknowledge toggle through two bus flops.
// Assumes the slow clock is at least four times slower than the bus clock.
module kwd_post_chan #(
    parameter int               W       = 32,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_stb,
    input  logic [W-1:0] wdata,
    output logic         pending,
    output logic [W-1:0] hold,
    input  logic         sclk,
    input  logic         srst_n,
    output logic         land
);

    logic         req_q;
    logic [W-1:0] hold_q;
    logic         ack_s1, ack_s2;
    logic         req_s1, req_s2, seen_q;

    assign pending = req_q ^ ack_s2;
    assign hold    = hold_q;
    assign land    = req_s2 ^ seen_q;

    // Bus side: accept a write when idle, and synchronize the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            hold_q <= RST_VAL;
            ack_s1 <= 1'b0;
            ack_s2 <= 1'b0;
        end else begin
            if (wr_stb && !pending) begin
                req_q  <= ~req_q;
                hold_q <= wdata;
            end
            ack_s1 <= seen_q;
            ack_s2 <= ack_s1;
        end
    end

    // Slow side: synchronize the request and record it once consumed.
    always_ff @(posedge sclk) begin
        if (!srst_n) begin
            req_s1 <= 1'b0;
            req_s2 <= 1'b0;
            seen_q <= 1'b0;
        end else begin
            req_s1 <= req_q;
            req_s2 <= req_s1;
            seen_q <= req_s2;
        end
    end

    // R3
    pend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> $past(wr_stb));

    // R4
    hold_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && $past(pending)) |-> $stable(hold_q));

endmodule

// File: rtl/kwd_cnt_mbox.sv
// Carries the slow counter to the bus clock. On every slow cycle the slow
// side copies the counter and flips a toggle. The bus side captures the copy
// one cycle after the synchronized toggle changes.
// Assumes the slow clock is at least four times slower than the bus clock.
module kwd_cnt_mbox #(
    parameter int W = 32
) (
    input  logic         sclk,
    input  logic         srst_n,
    input  logic [W-1:0] cnt_in,
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] snap
);

    logic [W-1:0] shadow_q;
    logic         tg_q;
    logic         t1, t2, t3;
    logic [W-1:0] snap_q;

    assign snap = snap_q;

    // Slow side: publish the counter value and mark it as new.
    always_ff @(posedge sclk) begin
        if (!srst_n) begin
            shadow_q <= '0;
            tg_q     <= 1'b0;
        end else begin
            shadow_q <= cnt_in;
            tg_q     <= ~tg_q;
        end
    end

    // Bus side: synchronize the toggle and capture on its change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t1     <= 1'b0;
            t2     <= 1'b0;
            t3     <= 1'b0;
            snap_q <= '0;
        end else begin
            t1 <= tg_q;
            t2 <= t1;
            t3 <= t2;
            if (t2 ^ t3) snap_q <= shadow_q;
        end
    end

endmodule

// File: rtl/kwd_core.sv
// Slow-domain watchdog engine: prescaler, key sequencer, up-counter with
// trigger reload, and the reset-request pulse stretcher. It acts on landing
// pulses from the posted channels. The landed data is stable while `land`
// is high.
module kwd_core
    import kwd_pkg::*;
#(
    parameter int                DATA_W     = 32,
    parameter int                EXP_W      = 3,
    parameter int                RST_CYCLES = 4,
    parameter logic [DATA_W-1:0] LOAD_INIT  = 32'hFFFF_FFF0
) (
    input  logic              sclk,
    input  logic              srst_n,
    input  logic [NUM_CH-1:0] land,
    input  logic [EXP_W:0]    ctrl_d,
    input  logic [DATA_W-1:0] load_d,
    input  logic [DATA_W-1:0] trig_d,
    input  logic [DATA_W-1:0] key_d,
    output logic [DATA_W-1:0] cnt_o,
    output logic              rst_req_o
);

    localparam int PRE_W = (1 << EXP_W) - 1;
    localparam int RC_W  = $clog2(RST_CYCLES + 1);

    logic              pre_en_q;
    logic [EXP_W-1:0]  exp_q;
    logic [PRE_W-1:0]  pre_cnt_q;
    logic [PRE_W-1:0]  pre_lim;
    logic [DATA_W-1:0] load_q;
    logic [DATA_W-1:0] last_trig_q;
    logic [DATA_W-1:0] cnt_q;
    logic              run_q;
    kwd_key_e          key_st_q;
    logic [RC_W-1:0]   rc_q;
    logic              tick, reload, step, wrap;

    assign cnt_o     = cnt_q;
    assign rst_req_o = (rc_q != '0);

    // Tick, reload and wrap decisions for this slow cycle.
    always_comb begin
        pre_lim = (PRE_W'(1) << exp_q) - PRE_W'(1);
        tick    = !pre_en_q || (pre_cnt_q == pre_lim);
        reload  = land[CH_TRIG] && (trig_d != last_trig_q);
        step    = run_q && tick && !reload;
        wrap    = step && (&cnt_q);
    end

    // Prescaler: take new settings on a control landing, else divide.
    always_ff @(posedge sclk) begin
        if (!srst_n) begin
            pre_en_q  <= 1'b0;
            exp_q     <= '0;
            pre_cnt_q <= '0;
        end else if (land[CH_CTRL]) begin
            pre_en_q  <= ctrl_d[EXP_W];
            exp_q     <= ctrl_d[EXP_W-1:0];
            pre_cnt_q <= '0;
        end else if (pre_en_q && !tick) begin
            pre_cnt_q <= pre_cnt_q + PRE_W'(1);
        end else begin
            pre_cnt_q <= '0;
        end
    end

    // Load value taken when its posted write lands.
    always_ff @(posedge sclk) begin
        if (!srst_n)             load_q <= LOAD_INIT;
        else if (land[CH_LOAD])  load_q <= load_d;
    end

    // Counter: a fresh trigger reloads it, otherwise it counts while running.
    always_ff @(posedge sclk) begin
        if (!srst_n) begin
            cnt_q       <= LOAD_INIT;
            last_trig_q <= '0;
        end else if (reload) begin
            cnt_q       <= load_q;
            last_trig_q <= trig_d;
        end else if (step) begin
            cnt_q <= cnt_q + DATA_W'(1);
        end
    end

    // Key sequencer: two matching words change the run state.
    always_ff @(posedge sclk) begin
        if (!srst_n) begin
            key_st_q <= KS_IDLE;
            run_q    <= 1'b0;
        end else if (land[CH_KEY]) begin
            case (key_st_q)
                KS_IDLE: begin
                    if (key_d == DATA_W'(KEY_ON_1))       key_st_q <= KS_ON;
                    else if (key_d == DATA_W'(KEY_OFF_1)) key_st_q <= KS_OFF;
                end
                KS_ON: begin
                    if (key_d == DATA_W'(KEY_ON_2)) run_q <= 1'b1;
                    key_st_q <= KS_IDLE;
                end
                default: begin
                    if (key_d == DATA_W'(KEY_OFF_2)) run_q <= 1'b0;
                    key_st_q <= KS_IDLE;
                end
            endcase
        end
    end

    // Reset-request stretcher started by a counter wrap.
    always_ff @(posedge sclk) begin
        if (!srst_n)          rc_q <= '0;
        else if (wrap)        rc_q <= RC_W'(RST_CYCLES);
        else if (rc_q != '0)  rc_q <= rc_q - RC_W'(1);
    end

    // R5 R6 R7
    run_by_key_chk: assert property (@(posedge sclk) disable iff (!srst_n)
        !$stable(run_q) |-> $past(land[CH_KEY]));

    // R8
    stopped_hold_chk: assert property (@(posedge sclk) disable iff (!srst_n)
        (!run_q && !land[CH_TRIG]) |=> $stable(cnt_q));

    // R10
    same_trig_chk: assert property (@(posedge sclk) disable iff (!srst_n)
        (land[CH_TRIG] && (trig_d == last_trig_q) && !(run_q && tick))
            |=> $stable(cnt_q));

    // R11
    req_from_run_chk: assert property (@(posedge sclk) disable iff (!srst_n)
        $rose(rst_req_o) |-> $past(run_q));

endmodule

// File: rtl/keyed_watchdog.sv
// Top of the keyed watchdog. It decodes the bus into four posted-write
// channels (control, load, trigger, key), feeds their landings to the slow
// engine, and serves reads combinationally from bus-side copies and the
// counter snapshot.
// Assumes sclk is at least four times slower than clk, and DATA_W >= 16.
module keyed_watchdog
    import kwd_pkg::*;
#(
    parameter int                DATA_W     = 32,
    parameter int                EXP_W      = 3,
    parameter int                RST_CYCLES = 4,
    parameter logic [7:0]        REV_CODE   = 8'h2A,
    parameter logic [DATA_W-1:0] LOAD_INIT  = 32'hFFFF_FFF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [2:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              sclk,
    input  logic              srst_n,
    output logic              wdt_rst_req
);

    localparam int                EN_BIT    = 2 + EXP_W;
    localparam logic [DATA_W-1:0] CTRL_MASK = DATA_W'(((1 << (EXP_W + 1)) - 1) << 2);

    logic [NUM_CH-1:0] wr_stb;
    logic [NUM_CH-1:0] pend;
    logic [NUM_CH-1:0] land;
    logic [DATA_W-1:0] hold [NUM_CH];
    logic [DATA_W-1:0] cnt;
    logic [DATA_W-1:0] snap;
    logic [DATA_W-1:0] pend_word;

    // One posted channel per writable register.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        localparam logic [DATA_W-1:0] RV = (ch == CH_LOAD) ? LOAD_INIT : '0;

        assign wr_stb[ch] = bus_valid && bus_write && (bus_addr == ch_addr(ch));

        kwd_post_chan #(.W(DATA_W), .RST_VAL(RV)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_stb  (wr_stb[ch]),
            .wdata   (bus_wdata),
            .pending (pend[ch]),
            .hold    (hold[ch]),
            .sclk    (sclk),
            .srst_n  (srst_n),
            .land    (land[ch])
        );
    end

    kwd_core #(
        .DATA_W     (DATA_W),
        .EXP_W      (EXP_W),
        .RST_CYCLES (RST_CYCLES),
        .LOAD_INIT  (LOAD_INIT)
    ) u_core (
        .sclk      (sclk),
        .srst_n    (srst_n),
        .land      (land),
        .ctrl_d    (hold[CH_CTRL][EN_BIT:2]),
        .load_d    (hold[CH_LOAD]),
        .trig_d    (hold[CH_TRIG]),
        .key_d     (hold[CH_KEY]),
        .cnt_o     (cnt),
        .rst_req_o (wdt_rst_req)
    );

    kwd_cnt_mbox #(.W(DATA_W)) u_mbox (
        .sclk   (sclk),
        .srst_n (srst_n),
        .cnt_in (cnt),
        .clk    (clk),
        .rst_n  (rst_n),
        .snap   (snap)
    );

    // Place each channel's pending flag at its register bit.
    always_comb begin
        pend_word = '0;
        for (int ch = 0; ch < NUM_CH; ch++) pend_word[ch_pend_bit(ch)] = pend[ch];
    end

    // Combinational read mux.
    always_comb begin
        case (kwd_addr_e'(bus_addr))
            A_REV:   bus_rdata = DATA_W'(REV_CODE);
            A_CTRL:  bus_rdata = hold[CH_CTRL] & CTRL_MASK;
            A_CNT:   bus_rdata = snap;
            A_LOAD:  bus_rdata = hold[CH_LOAD];
            A_TRIG:  bus_rdata = hold[CH_TRIG];
            A_KEY:   bus_rdata = hold[CH_KEY];
            A_PEND:  bus_rdata = pend_word;
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: tb/keyed_watchdog_tb_top.sv
// Bench: a timed behavioural model, stepped on both clocks, is compared
// against every bus read and every slow cycle of the reset request. Directed
// scenarios add named checks.
module keyed_watchdog_tb_top;

    localparam int          RSTC  = 4;
    localparam logic [7:0]  REV   = 8'h2A;
    localparam logic [31:0] LINIT = 32'hFFFF_FFF0;

    logic        clk = 1'b0;
    logic        sclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        srst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdt_rst_req;

    int n_vec = 0;
    int n_bad = 0;
    int pulse_hi = 0;
    bit done = 0;

    keyed_watchdog #(.RST_CYCLES(RSTC), .REV_CODE(REV), .LOAD_INIT(LINIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk(sclk), .srst_n(srst_n), .wdt_rst_req(wdt_rst_req)
    );

    always #5 clk = ~clk;
    initial begin
        #1;
        forever #40 sclk = ~sclk;
    end

    // ---------------- reference model ----------------
    bit          m_pend [4];
    int          m_sage [4];
    int          m_bage [4];
    logic [31:0] m_hold [4];
    logic [31:0] m_snap, m_shadow;
    bit          m_mb_busy;
    int          m_mb_age;
    logic [31:0] m_cnt, m_load, m_last;
    bit          m_run, m_pre_en;
    int          m_ks, m_exp, m_pre, m_rc;

    function automatic int addr_ch(logic [2:0] a);
        case (a)
            3'd1: return 0;
            3'd3: return 1;
            3'd4: return 2;
            3'd5: return 3;
            default: return -1;
        endcase
    endfunction

    // Bus-clock half of the model: acceptance, acknowledge aging, snapshot.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 4; c++) begin
                m_pend[c] = 0; m_sage[c] = 0; m_bage[c] = 0; m_hold[c] = '0;
            end
            m_hold[1] = LINIT;
            m_snap = '0;
            m_mb_busy = 0;
        end else begin
            int wc;
            wc = addr_ch(bus_addr);
            for (int c = 0; c < 4; c++)
                if (m_pend[c] && m_sage[c] == 3) begin
                    m_bage[c]++;
                    if (m_bage[c] == 2) m_pend[c] = 0;
                end
            if (bus_valid && bus_write && wc >= 0 && !m_pend[wc]) begin
                m_pend[wc] = 1; m_sage[wc] = 0; m_bage[wc] = 0;
                m_hold[wc] = bus_wdata;
            end
            if (m_mb_busy) begin
                m_mb_age++;
                if (m_mb_age == 3) begin
                    m_snap = m_shadow;
                    m_mb_busy = 0;
                end
            end
        end
    end

    // Slow-clock half of the model: landings, prescale, count, keys, pulse.
    always @(posedge sclk) begin
        if (!srst_n) begin
            m_cnt = LINIT; m_load = LINIT; m_last = '0; m_run = 0; m_ks = 0;
            m_pre_en = 0; m_exp = 0; m_pre = 0; m_rc = 0;
        end else begin
            bit lnd [4];
            bit tick, rel, stp, wrp;
            m_shadow = m_cnt; m_mb_busy = 1; m_mb_age = 0;
            for (int c = 0; c < 4; c++) begin
                lnd[c] = 0;
                if (m_pend[c] && m_sage[c] < 3) begin
                    m_sage[c]++;
                    if (m_sage[c] == 3) lnd[c] = 1;
                end
            end
            tick = !m_pre_en || (m_pre == (1 << m_exp) - 1);
            rel  = lnd[2] && (m_hold[2] != m_last);
            stp  = m_run && tick && !rel;
            wrp  = stp && (m_cnt == 32'hFFFF_FFFF);
            if (lnd[0]) begin
                m_pre_en = m_hold[0][5]; m_exp = int'(m_hold[0][4:2]); m_pre = 0;
            end else if (m_pre_en && !tick) m_pre++;
            else m_pre = 0;
            if (wrp) m_rc = RSTC;
            else if (m_rc > 0) m_rc--;
            if (rel) begin m_cnt = m_load; m_last = m_hold[2]; end
            else if (stp) m_cnt = m_cnt + 1;
            if (lnd[1]) m_load = m_hold[1];
            if (lnd[3]) begin
                case (m_ks)
                    0: if (m_hold[3] == 32'h0000_BBBB) m_ks = 1;
                       else if (m_hold[3] == 32'h0000_AAAA) m_ks = 2;
                    1: begin if (m_hold[3] == 32'h0000_4444) m_run = 1; m_ks = 0; end
                    default: begin if (m_hold[3] == 32'h0000_5555) m_run = 0; m_ks = 0; end
                endcase
            end
        end
    end

    function automatic logic [31:0] exp_rd(logic [2:0] a);
        case (a)
            3'd0: return {24'd0, REV};
            3'd1: return m_hold[0] & 32'h3C;
            3'd2: return m_snap;
            3'd3: return m_hold[1];
            3'd4: return m_hold[2];
            3'd5: return m_hold[3];
            3'd6: return {27'd0, m_pend[3], m_pend[2], m_pend[1], 1'b0, m_pend[0]};
            default: return '0;
        endcase
    endfunction

    function automatic string tag_of(logic [2:0] a);
        if (a == 3'd2) return "R12";
        if (a == 3'd6) return "R3";
        return "R2";
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
        n_vec++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, expv, $time);
        end
    endtask

    // Per-bus-cycle comparison of the read port against the model.
    always @(negedge clk) begin
        #2;
        if (rst_n && !done) chk(tag_of(bus_addr), bus_rdata, exp_rd(bus_addr));
    end

    // Per-slow-cycle comparison of the reset request (R11).
    always @(negedge sclk) begin
        if (srst_n && !done) begin
            chk("R11", {31'd0, wdt_rst_req}, {31'd0, m_rc != 0});
            if (wdt_rst_req) pulse_hi++;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic bus_wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #3;
        d = bus_rdata;
    endtask

    task automatic wait_free(int c);
        while (m_pend[c]) @(negedge clk);
    endtask

    task automatic idle_slow(int n);
        repeat (n * 8) begin
            @(negedge clk);
            bus_addr = bus_addr + 3'd1;
        end
    endtask

    task automatic post(logic [2:0] a, logic [31:0] d);
        bus_wr(a, d);
        wait_free(addr_ch(a));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, c0, c1;
        repeat (5) @(posedge sclk);
        @(negedge clk); rst_n = 1;
        @(negedge sclk); srst_n = 1;
        idle_slow(4);

        // R1 reset state
        rd(3'd3, v); chk("R1", v, LINIT);
        rd(3'd1, v); chk("R1", v, 32'h0);
        rd(3'd6, v); chk("R1", v, 32'h0);
        rd(3'd2, v); chk("R1", v, LINIT);
        chk("R1", {31'd0, wdt_rst_req}, 32'h0);
        rd(3'd0, v); chk("R2", v, {24'd0, REV});
        rd(3'd7, v); chk("R2", v, 32'h0);

        // R3 pending set, R4 write while pending dropped
        bus_wr(3'd5, 32'h0000_BBBB);
        rd(3'd6, v); chk("R3", v, 32'h10);
        bus_wr(3'd5, 32'h0000_4444);
        rd(3'd5, v); chk("R4", v, 32'h0000_BBBB);
        wait_free(3);
        post(3'd5, 32'h0000_4444);

        // R5 start, R8 counting one per slow cycle
        rd(3'd2, c0);
        idle_slow(6);
        rd(3'd2, c1);
        chk("R5", {31'd0, c1 != c0}, 32'd1);
        chk("R8", {31'd0, (c1 - c0) >= 5 && (c1 - c0) <= 7}, 32'd1);

        // R11 wrap pulse
        idle_slow(20);
        chk("R11", pulse_hi, RSTC);
        rd(3'd2, v); chk("R11", {31'd0, v < 32'd40}, 32'd1);

        // R6 stop holds the counter
        post(3'd5, 32'h0000_AAAA);
        post(3'd5, 32'h0000_5555);
        idle_slow(2);
        rd(3'd2, c0); idle_slow(10); rd(3'd2, c1);
        chk("R6", c1, c0);

        // R7 broken sequence keeps timer stopped
        post(3'd5, 32'h0000_BBBB);
        post(3'd5, 32'h0000_1234);
        idle_slow(2);
        rd(3'd2, c0); idle_slow(10); rd(3'd2, c1);
        chk("R7", c1, c0);

        // R10 trigger reload only on a new value
        post(3'd3, 32'hFFFF_FF00);
        post(3'd4, 32'h0000_1234);
        idle_slow(2);
        rd(3'd2, v); chk("R10", v, 32'hFFFF_FF00);
        post(3'd3, 32'h0000_0010);
        post(3'd4, 32'h0000_1234);
        idle_slow(2);
        rd(3'd2, v); chk("R10", v, 32'hFFFF_FF00);
        post(3'd4, 32'h0000_EDCB);
        idle_slow(2);
        rd(3'd2, v); chk("R10", v, 32'h0000_0010);

        // R9 prescaler divide by four
        post(3'd1, 32'h0000_0028);
        rd(3'd1, v); chk("R2", v, 32'h28);
        post(3'd3, 32'hFFFF_FFF8);
        post(3'd4, 32'h0000_1111);
        post(3'd5, 32'h0000_BBBB);
        post(3'd5, 32'h0000_4444);
        rd(3'd2, c0); idle_slow(20); rd(3'd2, c1);
        chk("R9", {31'd0, (c1 - c0) >= 4 && (c1 - c0) <= 6}, 32'd1);
        idle_slow(30);
        chk("R11", pulse_hi, 2 * RSTC);
        post(3'd5, 32'h0000_AAAA);
        post(3'd5, 32'h0000_5555);
        idle_slow(4);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule